// File: doc/BRIEF.md
# Victim Writeback Acceptance Controller

This block sits beside a shared second-level cache and handles victim writebacks that first-level caches push down to it. It tracks a small set of cache lines. Each line holds a stable coherence state (I, S, E, O or M), a dirty bit and a data word. When a victim request arrives for a line that is not already waiting, the block acknowledges it on the next cycle. It remembers the requester as the only permitted data source and parks the line in a waiting state. The waiting state records both the prior state and the target state.

The requester then sends either a data message, with dirty and shared flags, or a stale notice. A data message from the recorded sender writes the line, settles the final state and emits an unblock message toward the directory. The unblock carries a presence bit and an owner bit. A stale notice settles the line without writing data. A victim request that targets a line already waiting is refused with a same-cycle retry indication, and the requester must present it again later. A lookup port reads out the state, busy flag, dirty bit and data of any line.

Top module: `vwb_ctrl`

## Requirements
- R1: A victim request (req_valid) to a line that is not waiting is accepted. One cycle later, ack_valid pulses with ack_dst equal to the requester ID and ack_line equal to the line. From then until it settles, the line reads busy on the lookup port. No request means no ack.
- R2: The request kinds are encoded on req_kind as 0 dirty, 1 dirty-shared, 2 clean and 3 clean-shared. The state codes on look_state are 0 I, 1 S, 2 E, 3 O and 4 M. From I, these are the final states on data:
  - dirty with unshared data gives M, and dirty with shared data gives O;
  - dirty-shared gives O;
  - clean with unshared data gives E, and clean with shared data gives S;
  - clean-shared gives S.
- R3: From a held state, the request kind picks a target state:
  - from M: dirty gives M, dirty-shared gives O, clean gives E and clean-shared gives S;
  - from O: every kind gives O;
  - from E: clean-shared gives S and the rest give E;
  - from S: dirty-shared gives O, clean gives E and the rest give S.
  While a line waits, look_state keeps showing the prior state. Data with the shared flag set turns a target of M into O and a target of E into S.
- R4: A stale notice (rsp_stale=1) from the recorded sender leaves the data unchanged. For a line that was I, it returns the line to I with the dirty bit cleared and sends an unblock with unblk_present=0 and unblk_owner=0. For any other line, it restores the prior state and sends an unblock with unblk_present=1.
- R5: Every unblock caused by data has unblk_present=1. In every unblock, unblk_owner is 1 when the settled state is M, O or E and 0 when it is S. The unblock appears on the cycle after the response is taken.
- R6: A data message writes rsp_data into the line. The new dirty bit is the old dirty bit OR rsp_dirty, so clean data never clears it.
- R7: A victim request to a line that is waiting raises req_retry in the same cycle. It produces no ack and changes no line state.
- R8: A response for a line that is not waiting, or one whose rsp_src differs from the recorded sender, pulses proto_err on the next cycle. It produces no unblock and leaves the line unchanged.
- R9: After reset, every line is I, not busy, clean, and holds data 0. No ack, unblock or error is pending.
- R10: A request and a response in the same cycle are handled independently. A request to the line that the response settles is retried, because that line is still waiting in that cycle. A request to another line is acknowledged in the same cycle as the unblock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Victim request present |
| req_kind | input | 2 | Victim kind (0 dirty, 1 dirty-shared, 2 clean, 3 clean-shared) |
| req_line | input | LINE_W | Line index of the victim |
| req_src | input | SRC_W | Requester ID |
| req_retry | output | 1 | Request refused this cycle; present it again later |
| ack_valid | output | 1 | Writeback acknowledgement pulse |
| ack_dst | output | SRC_W | Requester being acknowledged |
| ack_line | output | LINE_W | Line being acknowledged |
| rsp_valid | input | 1 | Data or stale message present |
| rsp_stale | input | 1 | 1 means a stale notice, 0 means data |
| rsp_line | input | LINE_W | Line index of the message |
| rsp_src | input | SRC_W | Sender ID |
| rsp_dirty | input | 1 | Incoming data is dirty |
| rsp_shared | input | 1 | Incoming data is shared |
| rsp_data | input | DATA_W | Data word |
| unblk_valid | output | 1 | Unblock message pulse |
| unblk_line | output | LINE_W | Line being unblocked |
| unblk_present | output | 1 | Line remains valid after settling |
| unblk_owner | output | 1 | Settled state is M, O or E |
| proto_err | output | 1 | Unexpected or wrong-sender response |
| look_line | input | LINE_W | Line selected for lookup |
| look_state | output | 3 | Stable state of the selected line |
| look_busy | output | 1 | Selected line is waiting |
| look_dirty | output | 1 | Dirty bit of the selected line |
| look_data | output | DATA_W | Data of the selected line |

## Verification
A victim request and a settling response can arrive in the same cycle. The bench drives both together twice. In the first case both target the same waiting line: it expects req_retry high, no ack, and an unblock with the final state. In the second case the request targets an idle line while the response settles another: it expects an ack and an unblock in the same output cycle. The scoreboard queues decide each case by matching every emitted ack and unblock against the predicted items, in order.

// File: rtl/vwb_pkg.sv
package vwb_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_state_e;

    typedef enum logic [1:0] {
        VK_DIRTY    = 2'd0,
        VK_DIRTY_SH = 2'd1,
        VK_CLEAN    = 2'd2,
        VK_CLEAN_SH = 2'd3
    } vic_kind_e;

    function automatic logic owns_line(line_state_e st);
        return (st == ST_M) || (st == ST_O) || (st == ST_E);
    endfunction

endpackage

// File: rtl/vwb_victim_decode.sv
module vwb_victim_decode
    import vwb_pkg::*;
(
    input  line_state_e prior,
    input  logic        busy,
    input  vic_kind_e   kind,
    output logic        accept,
    output line_state_e target
);

    always_comb begin
        accept = !busy;
        target = ST_S;
        unique case (prior)
            ST_I, ST_M: begin
                unique case (kind)
                    VK_DIRTY:    target = ST_M;
                    VK_DIRTY_SH: target = ST_O;
                    VK_CLEAN:    target = ST_E;
                    default:     target = ST_S;
                endcase
            end
            ST_O: target = ST_O;
            ST_E: target = (kind == VK_CLEAN_SH) ? ST_S : ST_E;
            default: begin
                unique case (kind)
                    VK_DIRTY_SH: target = ST_O;
                    VK_CLEAN:    target = ST_E;
                    default:     target = ST_S;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/vwb_resolve.sv
module vwb_resolve
    import vwb_pkg::*;
(
    input  line_state_e prior,
    input  line_state_e target,
    input  logic        stale,
    input  logic        shared,
    output line_state_e final_st,
    output logic        present,
    output logic        owner
);

    line_state_e demoted;

    always_comb begin
        demoted = target;
        if (shared) begin
            if (target == ST_M) demoted = ST_O;
            else if (target == ST_E) demoted = ST_S;
        end
        final_st = stale ? prior : demoted;
        present  = (final_st != ST_I);
        owner    = owns_line(final_st);
    end

endmodule

// File: rtl/vwb_ctrl.sv
module vwb_ctrl
    import vwb_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int SRC_W     = 4,
    parameter int DATA_W    = 32,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [LINE_W-1:0] req_line,
    input  logic [SRC_W-1:0]  req_src,
    output logic              req_retry,
    output logic              ack_valid,
    output logic [SRC_W-1:0]  ack_dst,
    output logic [LINE_W-1:0] ack_line,
    input  logic              rsp_valid,
    input  logic              rsp_stale,
    input  logic [LINE_W-1:0] rsp_line,
    input  logic [SRC_W-1:0]  rsp_src,
    input  logic              rsp_dirty,
    input  logic              rsp_shared,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              unblk_valid,
    output logic [LINE_W-1:0] unblk_line,
    output logic              unblk_present,
    output logic              unblk_owner,
    output logic              proto_err,
    input  logic [LINE_W-1:0] look_line,
    output logic [2:0]        look_state,
    output logic              look_busy,
    output logic              look_dirty,
    output logic [DATA_W-1:0] look_data
);

    typedef struct packed {
        line_state_e       st;
        logic              dirty;
        logic [DATA_W-1:0] data;
        logic              busy;
        line_state_e       prior;
        line_state_e       target;
        logic [SRC_W-1:0]  src;
    } line_t;

    typedef struct packed {
        line_t [NUM_LINES-1:0] lines;
        logic                  ack_v;
        logic [SRC_W-1:0]      ack_dst;
        logic [LINE_W-1:0]     ack_line;
        logic                  unb_v;
        logic [LINE_W-1:0]     unb_line;
        logic                  unb_present;
        logic                  unb_owner;
        logic                  err;
    } state_t;

    state_t s_q, s_d;

    line_t       req_ent, rsp_ent;
    logic        dec_accept;
    line_state_e dec_target;
    line_state_e res_state;
    logic        res_present, res_owner;
    logic        rsp_match;

    assign req_ent   = s_q.lines[req_line];
    assign rsp_ent   = s_q.lines[rsp_line];
    assign rsp_match = rsp_ent.busy && (rsp_ent.src == rsp_src);

    vwb_victim_decode u_decode (
        .prior  (req_ent.st),
        .busy   (req_ent.busy),
        .kind   (vic_kind_e'(req_kind)),
        .accept (dec_accept),
        .target (dec_target)
    );

    vwb_resolve u_resolve (
        .prior    (rsp_ent.prior),
        .target   (rsp_ent.target),
        .stale    (rsp_stale),
        .shared   (rsp_shared),
        .final_st (res_state),
        .present  (res_present),
        .owner    (res_owner)
    );

    always_comb begin
        s_d       = s_q;
        s_d.ack_v = 1'b0;
        s_d.unb_v = 1'b0;
        s_d.err   = 1'b0;

        // victim request: acknowledge and park the line
        if (req_valid && dec_accept) begin
            s_d.lines[req_line].busy   = 1'b1;
            s_d.lines[req_line].prior  = req_ent.st;
            s_d.lines[req_line].target = dec_target;
            s_d.lines[req_line].src    = req_src;
            s_d.ack_v    = 1'b1;
            s_d.ack_dst  = req_src;
            s_d.ack_line = req_line;
        end

        // data or stale notice: settle the waiting line
        if (rsp_valid) begin
            if (rsp_match) begin
                s_d.lines[rsp_line].busy = 1'b0;
                s_d.lines[rsp_line].st   = res_state;
                if (!rsp_stale) begin
                    s_d.lines[rsp_line].data  = rsp_data;
                    s_d.lines[rsp_line].dirty = rsp_ent.dirty | rsp_dirty;
                end
                if (res_state == ST_I) begin
                    s_d.lines[rsp_line].dirty = 1'b0;
                end
                s_d.unb_v       = 1'b1;
                s_d.unb_line    = rsp_line;
                s_d.unb_present = res_present;
                s_d.unb_owner   = res_owner;
            end else begin
                s_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_retry     = req_valid && !dec_accept;
    assign ack_valid     = s_q.ack_v;
    assign ack_dst       = s_q.ack_dst;
    assign ack_line      = s_q.ack_line;
    assign unblk_valid   = s_q.unb_v;
    assign unblk_line    = s_q.unb_line;
    assign unblk_present = s_q.unb_present;
    assign unblk_owner   = s_q.unb_owner;
    assign proto_err     = s_q.err;
    assign look_state    = s_q.lines[look_line].st;
    assign look_busy     = s_q.lines[look_line].busy;
    assign look_dirty    = s_q.lines[look_line].dirty;
    assign look_data     = s_q.lines[look_line].data;

endmodule

// File: rtl/vwb_ctrl_chk.sv
module vwb_ctrl_chk #(
    parameter int NUM_LINES = 8,
    parameter int SRC_W     = 4,
    parameter int DATA_W    = 32,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [LINE_W-1:0] req_line,
    input logic [SRC_W-1:0]  req_src,
    input logic              req_retry,
    input logic              ack_valid,
    input logic [SRC_W-1:0]  ack_dst,
    input logic [LINE_W-1:0] ack_line,
    input logic              rsp_valid,
    input logic              unblk_valid,
    input logic              unblk_present,
    input logic              unblk_owner,
    input logic              proto_err
);

    AST_ACK_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_retry) |=> (ack_valid && ack_dst == $past(req_src) && ack_line == $past(req_line))); // R1

    AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !ack_valid); // R1

    AST_NO_ACK_ON_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_retry) |=> !ack_valid); // R7

    AST_ABSENT_NOT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (unblk_valid && !unblk_present) |-> !unblk_owner); // R4

    AST_ERR_EXCLUDES_UNBLK: assert property (@(posedge clk) disable iff (!rst_n)
        !(proto_err && unblk_valid)); // R8

    AST_NO_RSP_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |=> (!unblk_valid && !proto_err)); // R8

endmodule

bind vwb_ctrl vwb_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .SRC_W     (SRC_W),
    .DATA_W    (DATA_W)
) u_chk (.*);

// File: tb/vwb_ctrl_bench.sv
module vwb_ctrl_bench;

    localparam int NUM_LINES = 8;
    localparam int SRC_W     = 4;
    localparam int DATA_W    = 32;
    localparam int LINE_W    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_kind = '0;
    logic [LINE_W-1:0] req_line = '0;
    logic [SRC_W-1:0]  req_src = '0;
    logic              req_retry;
    logic              ack_valid;
    logic [SRC_W-1:0]  ack_dst;
    logic [LINE_W-1:0] ack_line;
    logic              rsp_valid = 1'b0;
    logic              rsp_stale = 1'b0;
    logic [LINE_W-1:0] rsp_line = '0;
    logic [SRC_W-1:0]  rsp_src = '0;
    logic              rsp_dirty = 1'b0;
    logic              rsp_shared = 1'b0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic              unblk_valid;
    logic [LINE_W-1:0] unblk_line;
    logic              unblk_present;
    logic              unblk_owner;
    logic              proto_err;
    logic [LINE_W-1:0] look_line = '0;
    logic [2:0]        look_state;
    logic              look_busy;
    logic              look_dirty;
    logic [DATA_W-1:0] look_data;

    always #4 clk = ~clk;

    vwb_ctrl #(.NUM_LINES(NUM_LINES), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_vwb_ctrl (.*);

    localparam logic [1:0] K_D = 2'd0, K_DS = 2'd1, K_C = 2'd2, K_CS = 2'd3;
    localparam logic [2:0] S_I = 3'd0, S_S = 3'd1, S_E = 3'd2, S_O = 3'd3, S_M = 3'd4;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [SRC_W+LINE_W-1:0] q_ack[$];
    string                   q_ack_tag[$];
    logic [LINE_W+1:0]       q_unb[$];
    string                   q_unb_tag[$];

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare every emitted ack and unblock against predictions
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ack_valid) begin
                if (q_ack.size() == 0) chk("R1 unexpected ack", {ack_dst, ack_line}, '1);
                else chk(q_ack_tag.pop_front(), {ack_dst, ack_line}, q_ack.pop_front());
            end
            if (unblk_valid) begin
                if (q_unb.size() == 0) chk("R5 unexpected unblock", {unblk_line, unblk_present, unblk_owner}, '1);
                else chk(q_unb_tag.pop_front(), {unblk_line, unblk_present, unblk_owner}, q_unb.pop_front());
            end
        end
    end

    task automatic victim(string tag, int line, logic [1:0] kind, int src, bit exp_retry);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_line = line[LINE_W-1:0]; req_src = src[SRC_W-1:0];
        if (!exp_retry) begin
            q_ack.push_back({src[SRC_W-1:0], line[LINE_W-1:0]});
            q_ack_tag.push_back({tag, " ack"});
        end
        #1 chk({tag, " retry"}, req_retry, exp_retry);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic respond(string tag, int line, int src, bit stale, bit dirty, bit shared,
                           logic [DATA_W-1:0] data, bit exp_err, bit exp_present, bit exp_owner);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_line = line[LINE_W-1:0]; rsp_src = src[SRC_W-1:0];
        rsp_stale = stale; rsp_dirty = dirty; rsp_shared = shared; rsp_data = data;
        if (!exp_err) begin
            q_unb.push_back({line[LINE_W-1:0], exp_present, exp_owner});
            q_unb_tag.push_back({tag, " unblock"});
        end
        @(negedge clk);
        rsp_valid = 1'b0;
        chk({tag, " proto_err"}, proto_err, exp_err);
    endtask

    task automatic look(string tag, int line, logic [2:0] st, bit busy, bit dirty, logic [DATA_W-1:0] data);
        look_line = line[LINE_W-1:0];
        #1;
        chk({tag, " state"}, look_state, st);
        chk({tag, " busy"}, look_busy, busy);
        chk({tag, " dirty"}, look_dirty, dirty);
        chk({tag, " data"}, look_data, data);
    endtask

    initial begin
        #(8 * 200000);
        chk("watchdog expired", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        for (int i = 0; i < NUM_LINES; i++) look("R9 reset", i, S_I, 0, 0, 0);
        chk("R9 ack idle", ack_valid, 0);
        chk("R9 unblock idle", unblk_valid, 0);
        chk("R9 err idle", proto_err, 0);

        // R1 R2 fills from I
        victim("R1 dirty from I", 0, K_D, 3, 0);
        look("R1 busy while waiting", 0, S_I, 1, 0, 0);
        respond("R2 dirty unshared -> M", 0, 3, 0, 1, 0, 32'hA5A5_0000, 0, 1, 1);
        look("R2 line0 M", 0, S_M, 0, 1, 32'hA5A5_0000);

        victim("R2 dirty", 1, K_D, 2, 0);
        respond("R2 dirty shared data -> O", 1, 2, 0, 0, 1, 32'h1111, 0, 1, 1);
        look("R2 line1 O", 1, S_O, 0, 0, 32'h1111);

        victim("R2 dirty-shared", 2, K_DS, 5, 0);
        respond("R2 dirty-shared -> O", 2, 5, 0, 1, 0, 32'h2222, 0, 1, 1);
        look("R2 line2 O", 2, S_O, 0, 1, 32'h2222);

        victim("R2 clean", 3, K_C, 1, 0);
        respond("R2 clean unshared -> E", 3, 1, 0, 0, 0, 32'h3333, 0, 1, 1);
        look("R2 line3 E", 3, S_E, 0, 0, 32'h3333);

        victim("R2 clean", 4, K_C, 1, 0);
        respond("R5 clean shared -> S no owner", 4, 1, 0, 0, 1, 32'h4444, 0, 1, 0);
        look("R2 line4 S", 4, S_S, 0, 0, 32'h4444);

        victim("R2 clean-shared", 5, K_CS, 7, 0);
        respond("R2 clean-shared -> S", 5, 7, 0, 0, 0, 32'h5555, 0, 1, 0);
        look("R2 line5 S", 5, S_S, 0, 0, 32'h5555);

        // R4 stale from I
        victim("R4 dirty", 6, K_D, 4, 0);
        respond("R4 stale from I", 6, 4, 1, 1, 0, 32'hDEAD, 0, 0, 0);
        look("R4 line6 back to I", 6, S_I, 0, 0, 0);

        // R3 R7 R8 R6 on held M line
        victim("R3 M clean-shared", 0, K_CS, 9, 0);
        victim("R7 retry on waiting", 0, K_D, 9, 1);
        look("R7 line0 unchanged", 0, S_M, 1, 1, 32'hA5A5_0000);
        respond("R8 wrong sender", 0, 8, 0, 0, 0, 32'hBAD0, 1, 0, 0);
        look("R8 line0 unchanged", 0, S_M, 1, 1, 32'hA5A5_0000);
        respond("R3 M -> S", 0, 9, 0, 0, 0, 32'h1234, 0, 1, 0);
        look("R6 dirty sticky", 0, S_S, 0, 1, 32'h1234);

        // R4 stale restore on S
        victim("R3 S dirty-shared", 4, K_DS, 2, 0);
        respond("R4 stale restores S", 4, 2, 1, 1, 0, 32'hFFFF, 0, 1, 0);
        look("R4 line4 S unchanged", 4, S_S, 0, 0, 32'h4444);

        // R3 E and O rows
        victim("R3 E clean-shared", 3, K_CS, 1, 0);
        respond("R3 E -> S", 3, 1, 0, 0, 0, 32'h3131, 0, 1, 0);
        look("R3 line3 S", 3, S_S, 0, 0, 32'h3131);
        victim("R3 O clean", 2, K_C, 6, 0);
        respond("R3 O -> O", 2, 6, 0, 0, 0, 32'h2121, 0, 1, 1);
        look("R3 line2 O", 2, S_O, 0, 1, 32'h2121);

        // R8 response to idle line
        respond("R8 idle line", 7, 0, 0, 1, 0, 32'h7777, 1, 0, 0);
        look("R8 line7 untouched", 7, S_I, 0, 0, 0);

        // R10 same-line collision
        victim("R10 O clean", 1, K_C, 3, 0);
        @(negedge clk);
        req_valid = 1'b1; req_kind = K_D; req_line = 3'd1; req_src = 4'd4;
        rsp_valid = 1'b1; rsp_line = 3'd1; rsp_src = 4'd3; rsp_stale = 1'b0;
        rsp_dirty = 1'b0; rsp_shared = 1'b0; rsp_data = 32'hBEEF;
        q_unb.push_back({3'd1, 1'b1, 1'b1}); q_unb_tag.push_back("R10 same-line unblock");
        #1 chk("R10 same-line retry", req_retry, 1);
        @(negedge clk);
        req_valid = 1'b0; rsp_valid = 1'b0;
        chk("R10 no error", proto_err, 0);
        look("R10 line1 O", 1, S_O, 0, 0, 32'hBEEF);

        // R10 different-line collision
        victim("R10 retake", 1, K_D, 4, 0);
        @(negedge clk);
        req_valid = 1'b1; req_kind = K_C; req_line = 3'd7; req_src = 4'd2;
        rsp_valid = 1'b1; rsp_line = 3'd1; rsp_src = 4'd4; rsp_data = 32'hCAFE;
        q_ack.push_back({4'd2, 3'd7}); q_ack_tag.push_back("R10 cross ack");
        q_unb.push_back({3'd1, 1'b1, 1'b1}); q_unb_tag.push_back("R10 cross unblock");
        #1 chk("R10 cross accepted", req_retry, 0);
        @(negedge clk);
        req_valid = 1'b0; rsp_valid = 1'b0;
        chk("R10 both outputs", {ack_valid, unblk_valid}, 2'b11);
        respond("R2 line7 clean -> E", 7, 2, 0, 0, 0, 32'h7E7E, 0, 1, 1);
        look("R2 line7 E", 7, S_E, 0, 0, 32'h7E7E);

        repeat (3) @(negedge clk);
        chk("R1 all acks seen", q_ack.size(), 0);
        chk("R5 all unblocks seen", q_unb.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule